// File: doc/BRIEF.md
# Split Base-and-Bound Address Translator

This block relocates and range-checks the addresses of a small protected processor. It keeps two independent segments, each described by a base and a bound. The program segment serves instruction fetches, which take their address from the program counter. The data segment serves loads and stores. For each request the block adds the segment base to the effective address to form a physical address. It raises a fault, and withholds the physical-address-valid strobe, whenever the effective address is at or beyond the segment length or the addition overflows.

The two translation paths are purely combinational and independent, so one fetch and one data access can be translated in the same cycle. The four segment registers are reached through a configuration port. That port only acts in supervisor mode. A write attempted from user mode changes nothing and produces a one-cycle privilege-error pulse. After reset every base and bound is zero, so every access faults until supervisor code sets up the segments.

Top module: `bb_xlate_top`

## Requirements
- R1: For an in-range request, the physical address equals the segment base plus the effective address, and the valid strobe is high in the same cycle.
- R2: A request whose effective address is greater than or equal to the segment bound (unsigned) raises the fault output.
- R3: A request whose base-plus-address sum carries out of the address width raises the fault output, even when the address is below the bound.
- R4: Fetch requests use the program base and bound. Data requests use the data base and bound.
- R5: A fetch and a data access presented in the same cycle are both translated in that cycle, each independently of the other.
- R6: A faulting request leaves its valid strobe low. With no request, both the valid strobe and the fault output of that path are low.
- R7: In supervisor mode a write stores `cfg_wdata` into the register chosen by `cfg_sel`, and the new value is used from the next cycle on. The select encoding is: bit 1 chooses the segment (0 program, 1 data) and bit 0 chooses the field (0 base, 1 bound). A supervisor read returns that register's value combinationally.
- R8: A write with `supervisor` low leaves all registers unchanged, and `priv_err` is high for exactly the one cycle after the attempt.
- R9: A read with `supervisor` low returns zero on `cfg_rdata`.
- R10: After reset all bases and bounds read as zero, every request faults, and `priv_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supervisor | input | 1 | High when the processor runs in supervisor mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (bit 1 segment, bit 0 field) |
| cfg_wdata | input | AW | Write data |
| cfg_rdata | output | AW | Read data, zero outside supervisor mode |
| priv_err | output | 1 | One-cycle pulse after a user-mode write attempt |
| if_req | input | 1 | Fetch request |
| if_pc | input | AW | Program counter (effective fetch address) |
| if_paddr | output | AW | Physical fetch address |
| if_pvalid | output | 1 | Physical fetch address may be issued |
| if_fault | output | 1 | Fetch bounds violation |
| dm_req | input | 1 | Load or store request |
| dm_addr | input | AW | Effective data address |
| dm_paddr | output | AW | Physical data address |
| dm_pvalid | output | 1 | Physical data address may be issued |
| dm_fault | output | 1 | Data bounds violation |

## Verification
A fetch and a data access can both be translated in the same cycle. A register write can also land in the cycle right before a translation that depends on it. The bench drives both request ports together in every random cycle, using different segment settings for the two paths. This way, a path that reads the wrong pair, or that is disturbed by the other path, shows a wrong address or a wrong fault. After each supervisor or user write, the bench issues translations and compares them against a shadow copy of the registers that it updates only on supervisor writes.

// File: rtl/bb_xlate_pkg.sv
// Shared definitions for the base-and-bound translator.
// Assumes a two-bit register select: bit 1 picks the segment, bit 0 the field.
package bb_xlate_pkg;
    localparam int unsigned NUM_SEGS   = 2;
    localparam int unsigned NUM_FIELDS = 2;
    localparam int unsigned NUM_REGS   = NUM_SEGS * NUM_FIELDS;
    localparam int unsigned SEL_W      = $clog2(NUM_REGS);

    typedef enum logic [SEL_W-1:0] {
        SEL_PROG_BASE  = 2'd0,
        SEL_PROG_BOUND = 2'd1,
        SEL_DATA_BASE  = 2'd2,
        SEL_DATA_BOUND = 2'd3
    } seg_sel_e;
endpackage

// File: rtl/bb_seg_regs.sv
// Segment register file: four base/bound registers behind a privilege gate.
// Writes and reads act only in supervisor mode. A user-mode write is dropped
// and flagged by a one-cycle pulse in the cycle after the attempt.
// Assumes a synchronous active-low reset that clears every register.
module bb_seg_regs
    import bb_xlate_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supervisor,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    output logic             priv_err,
    output logic [AW-1:0]    prog_base,
    output logic [AW-1:0]    prog_bound,
    output logic [AW-1:0]    data_base,
    output logic [AW-1:0]    data_bound
);
    logic [AW-1:0] regs_q [NUM_REGS];
    logic          user_wr;

    assign user_wr = cfg_we && !supervisor;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Hold one segment register; load on a supervisor write that selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (cfg_we && supervisor && (cfg_sel == SEL_W'(i)))
                regs_q[i] <= cfg_wdata;
        end

        AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            user_wr |=> $stable(regs_q[i])); // R8
    end

    // Flag a user-mode write attempt for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_err <= 1'b0;
        else        priv_err <= user_wr;
    end

    // Return the selected register to supervisor code, zero otherwise.
    always_comb begin
        cfg_rdata = supervisor ? regs_q[cfg_sel] : '0;
    end

    assign prog_base  = regs_q[SEL_PROG_BASE];
    assign prog_bound = regs_q[SEL_PROG_BOUND];
    assign data_base  = regs_q[SEL_DATA_BASE];
    assign data_bound = regs_q[SEL_DATA_BOUND];

    AST_PRIV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        user_wr |=> priv_err); // R8
    AST_PRIV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        priv_err |-> $past(cfg_we) && !$past(supervisor)); // R8
    AST_USER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !supervisor |-> cfg_rdata == '0); // R9
endmodule

// File: rtl/bb_seg_xlate.sv
// One combinational translation path: relocate an effective address by a
// segment base and check it against the segment length. Faults on an
// address at or past the bound and on a carry out of the addition.
// The clock and reset are used only by the local assertions.
module bb_seg_xlate #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] eff_addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] bound,
    output logic [AW-1:0] paddr,
    output logic          pvalid,
    output logic          fault
);
    localparam int unsigned SW = AW + 1;

    logic [SW-1:0] sum;
    logic          out_of_range;
    logic          carry;

    // Form the relocated address and the violation condition.
    always_comb begin
        sum          = {1'b0, base} + {1'b0, eff_addr};
        carry        = sum[AW];
        out_of_range = (eff_addr >= bound);
        paddr        = sum[AW-1:0];
        fault        = req && (out_of_range || carry);
        pvalid       = req && !(out_of_range || carry);
    end

    AST_VALID_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pvalid |-> eff_addr < bound); // R2
    AST_VALID_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        pvalid |-> paddr >= base); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> !pvalid && !fault); // R6
    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !pvalid); // R6
endmodule

// File: rtl/bb_xlate_top.sv
// Split base-and-bound translator: a program segment for fetches and a
// data segment for loads and stores, each with its own combinational path,
// plus a supervisor-only register file holding both segments.
module bb_xlate_top
    import bb_xlate_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supervisor,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    cfg_rdata,
    output logic             priv_err,
    input  logic             if_req,
    input  logic [AW-1:0]    if_pc,
    output logic [AW-1:0]    if_paddr,
    output logic             if_pvalid,
    output logic             if_fault,
    input  logic             dm_req,
    input  logic [AW-1:0]    dm_addr,
    output logic [AW-1:0]    dm_paddr,
    output logic             dm_pvalid,
    output logic             dm_fault
);
    logic [AW-1:0] prog_base, prog_bound, data_base, data_bound;

    bb_seg_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .supervisor (supervisor),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .priv_err   (priv_err),
        .prog_base  (prog_base),
        .prog_bound (prog_bound),
        .data_base  (data_base),
        .data_bound (data_bound)
    );

    bb_seg_xlate #(.AW(AW)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (if_req),
        .eff_addr (if_pc),
        .base     (prog_base),
        .bound    (prog_bound),
        .paddr    (if_paddr),
        .pvalid   (if_pvalid),
        .fault    (if_fault)
    );

    bb_seg_xlate #(.AW(AW)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (dm_req),
        .eff_addr (dm_addr),
        .base     (data_base),
        .bound    (data_bound),
        .paddr    (dm_paddr),
        .pvalid   (dm_pvalid),
        .fault    (dm_fault)
    );

    AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        if_pvalid |-> if_paddr == prog_base + if_pc); // R4
    AST_DATA_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        dm_pvalid |-> dm_paddr == data_base + dm_addr); // R4
endmodule

// File: tb/sim_bb_xlate_top.sv
module sim_bb_xlate_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          supervisor, cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata, cfg_rdata;
    logic          priv_err;
    logic          if_req, dm_req;
    logic [AW-1:0] if_pc, dm_addr, if_paddr, dm_paddr;
    logic          if_pvalid, if_fault, dm_pvalid, dm_fault;

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] shadow [4];

    always #4 clk = ~clk;

    bb_xlate_top #(.AW(AW)) u0 (.*);

    function automatic logic exp_fault(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                       input logic [AW-1:0] bnd);
        logic [AW:0] s;
        s = {1'b0, b} + {1'b0, a};
        return (a >= bnd) || s[AW];
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive both paths, then compare with the shadow model.
    task automatic xlate(input string req, input logic fr, input logic [AW-1:0] pc,
                         input logic dr, input logic [AW-1:0] da);
        logic f;
        @(negedge clk);
        if_req = fr; if_pc = pc; dm_req = dr; dm_addr = da;
        #1;
        f = exp_fault(pc, shadow[0], shadow[1]);
        check({req, " if_fault"},  AW'(if_fault),  AW'(fr && f));
        check({req, " if_pvalid"}, AW'(if_pvalid), AW'(fr && !f));
        if (fr && !f) check({req, " if_paddr"}, if_paddr, shadow[0] + pc);
        f = exp_fault(da, shadow[2], shadow[3]);
        check({req, " dm_fault"},  AW'(dm_fault),  AW'(dr && f));
        check({req, " dm_pvalid"}, AW'(dm_pvalid), AW'(dr && !f));
        if (dr && !f) check({req, " dm_paddr"}, dm_paddr, shadow[2] + da);
    endtask

    task automatic wr(input logic sup, input logic [1:0] sel, input logic [AW-1:0] v);
        @(negedge clk);
        supervisor = sup; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; supervisor = 1'b1;
        if (sup) shadow[sel] = v;
        check(sup ? "R7 no priv_err" : "R8 priv_err pulse", AW'(priv_err), AW'(!sup));
        @(negedge clk);
        check("R8 priv_err one cycle", AW'(priv_err), '0);
    endtask

    task automatic rd(input string req, input logic sup, input logic [1:0] sel);
        @(negedge clk);
        supervisor = sup; cfg_sel = sel;
        #1;
        check(req, cfg_rdata, sup ? shadow[sel] : '0);
        supervisor = 1'b1;
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        rst_n = 1'b0; supervisor = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        if_req = 1'b0; dm_req = 1'b0; if_pc = '0; dm_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        check("R10 priv_err low", AW'(priv_err), '0);
        for (int s = 0; s < 4; s++) rd("R10 reset register zero", 1'b1, 2'(s));
        xlate("R10 all fault", 1'b1, 32'h0, 1'b1, 32'h10);
        xlate("R6 idle", 1'b0, 32'h5, 1'b0, 32'h5);

        // R7 supervisor writes, separate pairs (R4)
        wr(1'b1, 2'd0, 32'h0001_0000);
        wr(1'b1, 2'd1, 32'h0000_1000);
        wr(1'b1, 2'd2, 32'h0008_0000);
        wr(1'b1, 2'd3, 32'h0000_0400);
        for (int s = 0; s < 4; s++) rd("R7 readback", 1'b1, 2'(s));
        rd("R9 user read zero", 1'b0, 2'd1);
        // R1 / R4 / R5 both in range together
        xlate("R1 R5 both in range", 1'b1, 32'h0000_0FFF, 1'b1, 32'h0000_03FF);
        // R2 bound edge exactly
        xlate("R2 at bound", 1'b1, 32'h0000_1000, 1'b1, 32'h0000_0400);
        // R4 address valid for data bound only / fetch only
        xlate("R4 pair select", 1'b1, 32'h0000_0800, 1'b1, 32'h0000_0800);
        // R8 user write ignored
        wr(1'b0, 2'd1, 32'h0000_0001);
        rd("R8 register unchanged", 1'b1, 2'd1);
        xlate("R8 translation unchanged", 1'b1, 32'h0000_0010, 1'b0, 32'h0);
        // R3 carry out with address below bound
        wr(1'b1, 2'd2, 32'hFFFF_FF00);
        wr(1'b1, 2'd3, 32'hFFFF_FFFF);
        xlate("R3 carry out", 1'b0, 32'h0, 1'b1, 32'h0000_0100);
        xlate("R3 no carry edge", 1'b0, 32'h0, 1'b1, 32'h0000_00FF);

        // Random mix: both paths every cycle
        for (int n = 0; n < 400; n++) begin
            if ((n % 25) == 0) begin
                logic [1:0] sel;
                sel = 2'($urandom());
                wr(($urandom() % 4) != 0, sel,
                   (sel[0]) ? ($urandom() >> ($urandom() % 24)) : $urandom());
            end
            xlate("R5 random dual", 1'($urandom()), $urandom() >> ($urandom() % 30),
                  1'($urandom()), $urandom() >> ($urandom() % 30));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule